// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits beside a floating-point datapath and folds the exception flags of each finished operation into the floating-point status word. With each operation it takes the 5-bit vector of raised exceptions and the present status word. It then checks the raised flags against the trap-enable mask held in that word. The updated word is captured in a register, and the block issues either a trap request or an advance-to-next-instruction indication.

When at least one raised flag is enabled, the operation traps. The enabled flags are reduced to the single flag of highest priority. That flag becomes the current-exception field, and the trap-type field is marked as an IEEE exception. The accrued field is left unchanged. When no enabled flag is raised, the current-exception field takes the raised vector exactly as it arrived, the accrued field collects the same bits, and the instruction pointer is allowed to advance.

Top module: `fexc_status_recorder`

## Requirements
- R1: Status word layout: trap-enable mask in bits 27:23, accrued field in bits 9:5, current field in bits 4:0, and trap-type field in bits 16:14. Inside each 5-bit field, bit 4 is invalid, bit 3 is overflow, bit 2 is underflow, bit 1 is divide-by-zero and bit 0 is inexact.
- R2: A trap is requested when the raised vector ANDed with the trap-enable mask is nonzero. `trap_req` and `pc_advance` are one-cycle pulses that appear together with the updated word, one clock after the accepted operation. Exactly one of the two pulses is high for each operation.
- R3: On a trap, the current field holds only the highest-priority enabled raised flag. The priority order is invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R4: On a trap, the accrued field keeps its incoming value and the trap-type field is written with code 1 (IEEE exception).
- R5: Without a trap, the current field equals the raised vector, the accrued field becomes its incoming value ORed with the raised vector, and `pc_advance` pulses.
- R6: An operation with no raised flags clears the current field, keeps the accrued field and pulses `pc_advance`.
- R7: All status bits outside the current and accrued fields pass through unchanged from `status_in`. The only exception is the trap-type field, which is rewritten on a trap.
- R8: While `op_valid` is low, `status_q` holds its value and neither pulse is asserted.
- R9: Asynchronous reset clears `status_q`, `trap_req` and `pc_advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation has completed this cycle |
| raised_exc | input | 5 | Exceptions raised by the operation |
| status_in | input | STAT_W | Present status word |
| status_q | output | STAT_W | Updated status word (registered) |
| trap_req | output | 1 | Trap request pulse |
| pc_advance | output | 1 | Advance-to-next-instruction pulse |

## Verification
The bench sweeps all 32 raised vectors against all 32 trap-enable masks. This covers every case: no flags raised, flags raised but all disabled (which accrues), and every combination of several enabled flags (which exercises the priority reduction). A varying background pattern in the non-field bits separates correct pass-through from overwriting. An idle cycle after each operation separates holding the word from recomputing it.

// File: rtl/fexc_pkg.sv
package fexc_pkg;
  localparam int EXC_W    = 5;
  localparam int CUR_LSB  = 0;
  localparam int ACC_LSB  = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;
  typedef logic [EXC_W-1:0] exc_vec_t;
endpackage

// File: rtl/fexc_trap_detect.sv
module fexc_trap_detect
  import fexc_pkg::*;
(
  input  exc_vec_t raised,
  input  exc_vec_t enable,
  output exc_vec_t masked,
  output logic     trap
);
  always_comb begin
    masked = raised & enable;
    trap   = |masked;
  end
endmodule

// File: rtl/fexc_priority_pick.sv
module fexc_priority_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  // The highest index wins; the flag encoding puts invalid at the top.
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N-1) begin : g_top
      assign pick[i] = req[i];
    end else begin : g_low
      assign pick[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end
endmodule

// File: rtl/fexc_status_merge.sv
module fexc_status_merge
  import fexc_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] status_in,
  input  exc_vec_t          raised,
  input  exc_vec_t          picked,
  input  logic              trap,
  output logic [STAT_W-1:0] status_nxt
);
  exc_vec_t cur_val;

  always_comb begin
    cur_val    = trap ? picked : raised;
    status_nxt = status_in;
    status_nxt[CUR_LSB +: EXC_W] = cur_val;
    if (trap) begin
      status_nxt[FTT_LSB +: FTT_W] = FTT_IEEE;
    end else begin
      status_nxt[ACC_LSB +: EXC_W] = status_in[ACC_LSB +: EXC_W] | cur_val;
    end
  end
endmodule

// File: rtl/fexc_status_recorder.sv
module fexc_status_recorder
  import fexc_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        raised_exc,
  input  logic [STAT_W-1:0] status_in,
  output logic [STAT_W-1:0] status_q,
  output logic              trap_req,
  output logic              pc_advance
);
  exc_vec_t          enable_mask;
  exc_vec_t          masked;
  exc_vec_t          picked;
  logic              trap_d;
  logic [STAT_W-1:0] status_nxt;
  logic [STAT_W-1:0] status_d;
  logic              trap_nxt;
  logic              adv_nxt;

  assign enable_mask = status_in[TEM_LSB +: EXC_W];

  fexc_trap_detect u_detect (
    .raised (raised_exc),
    .enable (enable_mask),
    .masked (masked),
    .trap   (trap_d)
  );

  fexc_priority_pick #(.N(EXC_W)) u_pick (
    .req  (masked),
    .pick (picked)
  );

  fexc_status_merge #(.STAT_W(STAT_W)) u_merge (
    .status_in  (status_in),
    .raised     (raised_exc),
    .picked     (picked),
    .trap       (trap_d),
    .status_nxt (status_nxt)
  );

  always_comb begin
    status_d = status_q;
    trap_nxt = 1'b0;
    adv_nxt  = 1'b0;
    if (op_valid) begin
      status_d = status_nxt;
      trap_nxt = trap_d;
      adv_nxt  = ~trap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      trap_req   <= 1'b0;
      pc_advance <= 1'b0;
    end else begin
      status_q   <= status_d;
      trap_req   <= trap_nxt;
      pc_advance <= adv_nxt;
    end
  end
endmodule

// File: rtl/fexc_status_recorder_chk.sv
module fexc_status_recorder_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [4:0]        raised_exc,
  input logic [STAT_W-1:0] status_in,
  input logic [STAT_W-1:0] status_q,
  input logic              trap_req,
  input logic              pc_advance
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (trap_req ^ pc_advance)); // R2
  AST_TRAP_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ((raised_exc & status_in[27:23]) != 5'd0)) |=> trap_req); // R2
  AST_SINGLE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($countones(status_q[4:0]) == 1)); // R3
  AST_TRAP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ((raised_exc & status_in[27:23]) != 5'd0)) |=>
      (status_q[9:5] == $past(status_in[9:5]) && status_q[16:14] == 3'd1)); // R4
  AST_CLEAN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && raised_exc == 5'd0) |=>
      (pc_advance && status_q[4:0] == 5'd0 && status_q[9:5] == $past(status_in[9:5]))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(status_q) && !trap_req && !pc_advance)); // R8
endmodule

bind fexc_status_recorder fexc_status_recorder_chk #(.STAT_W(STAT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .raised_exc (raised_exc),
  .status_in  (status_in),
  .status_q   (status_q),
  .trap_req   (trap_req),
  .pc_advance (pc_advance)
);

// File: tb/fexc_status_recorder_tb.sv
module fexc_status_recorder_tb_top;
  localparam int STAT_W = 32;

  logic              clk;
  logic              rst_n;
  logic              op_valid;
  logic [4:0]        raised_exc;
  logic [STAT_W-1:0] status_in;
  logic [STAT_W-1:0] status_q;
  logic              trap_req;
  logic              pc_advance;

  int checks;
  int errors;
  bit done;

  fexc_status_recorder #(.STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .raised_exc(raised_exc),
    .status_in(status_in), .status_q(status_q), .trap_req(trap_req),
    .pc_advance(pc_advance)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int lim;
    lim = 0;
    while (!done && lim < 20000) begin
      @(posedge clk);
      lim++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, exp_s, held;
    logic [4:0]  m, pick, cur;
    logic        tr;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; op_valid = 1'b0; raised_exc = '0;
    status_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 status", status_q, 32'h0);
    check("R9 pulses", {30'd0, trap_req, pc_advance}, 32'h0);
    rst_n = 1'b1;
    for (int en = 0; en < 32; en++) begin
      for (int rv = 0; rv < 32; rv++) begin
        base = 32'hA5C3_6E19 ^ (32'h0101_0101 * en) ^ (32'h0000_2400 * rv);
        base[27:23] = en[4:0];
        m  = rv[4:0] & en[4:0];
        tr = (m != 5'd0);
        if (m[4])      pick = 5'b10000;
        else if (m[3]) pick = 5'b01000;
        else if (m[2]) pick = 5'b00100;
        else if (m[1]) pick = 5'b00010;
        else           pick = m;
        cur   = tr ? pick : rv[4:0];
        exp_s = base;
        exp_s[4:0] = cur;
        if (tr) exp_s[16:14] = 3'd1;
        else    exp_s[9:5]   = base[9:5] | cur;
        @(negedge clk);
        op_valid = 1'b1; raised_exc = rv[4:0]; status_in = base;
        @(negedge clk);
        op_valid = 1'b0; status_in = ~base;
        // R1 R3 R4 R5 R6 R7: full word against the field-level model
        if (rv == 0)     check("R6 status", status_q, exp_s);
        else if (tr)     check("R3 R4 status", status_q, exp_s);
        else             check("R5 R7 status", status_q, exp_s);
        check("R2 trap_req", {31'd0, trap_req}, {31'd0, tr});
        check("R2 pc_advance", {31'd0, pc_advance}, {31'd0, ~tr});
        held = status_q;
        @(negedge clk);
        check("R8 hold", status_q, held);
        check("R8 pulses", {30'd0, trap_req, pc_advance}, 32'h0);
      end
    end
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 async clear", status_q, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule